// File: doc/BRIEF.md
# Bounded-Probe Flow Slot Search

This controller locates a slot in a hashed flow table whose collisions are resolved by linear probing. A request carries a starting hash, a five-field flow key and an operation. An insert asks where a new key may be placed. A find asks where an existing key is held. The controller walks consecutive slots through a synchronous table read port. When the walk goes past the last slot, it continues from slot 0. The controller returns one slot index and a status code.

Insert and find end their walks on different conditions. An insert stops at the first empty slot. An insert also stops at an occupied slot that already holds the requested key. A find passes over empty slots and stops only on an occupied slot whose key matches. Both give up after a programmable number of probes, called the skid limit, and then report that the search ran out of range. Software loads the skid limit while the controller is idle.

Top module: `flow_probe_ctrl`

## Requirements
- R1: Probe number i (counting from 0) reads slot `req_hash + i`. When that sum is equal to or greater than ENTRIES, the slot used is the sum ANDed with ENTRIES-1.
- R2: For an insert (`req_op` = 0), the first probed slot whose valid flag is 0 ends the search. It returns status OK (0) and that slot index.
- R3: For an insert, an occupied slot whose stored key equals the request key ends the search. It returns status EXISTS (1) and that slot index.
- R4: For a find (`req_op` = 1), a slot whose valid flag is 0 does not end the search. Probing continues with the next slot.
- R5: For a find, the first occupied slot whose stored key equals the request key ends the search. It returns status OK (0) and that slot index.
- R6: If the skid limit is used up and no probe has ended the search, the controller returns status RANGE (2). The index returned is the last slot probed.
- R7: Keys are compared on all fields, packed as {source address [295:168], destination address [167:40], source port [39:24], destination port [23:8], protocol [7:0]}. A difference in any single field means the key does not match.
- R8: Suppose a request is accepted at a clock edge and ends on probe k. Then `done` rises exactly 2*(k+1) edges later and stays high for one cycle only. `busy` is high from the cycle after the accepting edge until `done` rises. `busy` is low while `done` is high.
- R9: The skid limit loads from `cfg_skid` on an edge where `cfg_we` is high and `busy` is low. A value of 0 becomes 1, and any value above MAX_SKID (16) becomes MAX_SKID. A write while `busy` is high has no effect. After reset the limit is MAX_SKID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the skid limit (taken only while idle) |
| cfg_skid | input | 5 | Requested skid limit |
| req_valid | input | 1 | Start a search (accepted while busy is low) |
| req_op | input | 1 | 0 = insert, 1 = find |
| req_hash | input | HASH_W (6) | Starting hash |
| req_key | input | 296 | Flow key to search for |
| busy | output | 1 | Search in progress |
| ram_rd_en | output | 1 | Table read strobe |
| ram_rd_addr | output | log2(ENTRIES) (4) | Table slot to read |
| ram_rd_valid | input | 1 | Valid flag of the slot read, one cycle after the strobe |
| ram_rd_key | input | 296 | Stored key of the slot read, one cycle after the strobe |
| done | output | 1 | One-cycle result strobe |
| done_status | output | 2 | 0 OK, 1 EXISTS, 2 RANGE |
| done_index | output | log2(ENTRIES) (4) | Resulting slot index |

## Verification
The hardest cases to reach arise when the probe walk crosses the end of the table while the search is not yet resolved. One case is a find that has to step over holes and then wraps to slot 0. Another is an insert that reaches a duplicate only after wrapping. The bench sets up a fixed table: four holes, and keys that repeat every six slots so that every slot collides with others. It then sweeps starting hashes across the whole hash range, including values above the table size. The sweep uses several skid limits, including 0 and values above the maximum, and both operations. It also uses four keys: two present, one absent, and one that differs from a stored key in a single field. A separate case writes the skid limit in the middle of a long search and confirms from the result latency that the write had no effect.

// File: rtl/flow_probe_pkg.sv
package flow_probe_pkg;

  typedef struct packed {
    logic [127:0] src_addr;
    logic [127:0] dst_addr;
    logic [15:0]  src_port;
    logic [15:0]  dst_port;
    logic [7:0]   proto;
  } flow_key_t;

  localparam int KEY_W = $bits(flow_key_t);

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_EXISTS = 2'd1,
    ST_RANGE  = 2'd2
  } probe_status_e;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_WAIT = 2'd1,
    PS_CMP  = 2'd2
  } probe_state_e;

  localparam logic OP_INSERT = 1'b0;
  localparam logic OP_FIND   = 1'b1;

endpackage

// File: rtl/flow_key_cmp.sv
module flow_key_cmp
  import flow_probe_pkg::*;
(
  input  flow_key_t a,
  input  flow_key_t b,
  output logic      match
);
  localparam int N_FIELDS = 5;
  logic [N_FIELDS-1:0] field_eq;

  // R7: every field has its own comparator; all must agree
  always_comb begin
    field_eq[0] = (a.src_addr == b.src_addr);
    field_eq[1] = (a.dst_addr == b.dst_addr);
    field_eq[2] = (a.src_port == b.src_port);
    field_eq[3] = (a.dst_port == b.dst_port);
    field_eq[4] = (a.proto    == b.proto);
  end

  assign match = &field_eq;
endmodule

// File: rtl/flow_probe_slot.sv
module flow_probe_slot #(
  parameter int ENTRIES = 16,
  parameter int HASH_W  = 6,
  parameter int CNT_W   = 5
) (
  input  logic [HASH_W-1:0]          base,
  input  logic [CNT_W-1:0]           cnt,
  output logic [$clog2(ENTRIES)-1:0] slot
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int SUM_W = ((HASH_W > CNT_W) ? HASH_W : CNT_W) + 1;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;

  // R1: wrap by masking once the sum leaves the table
  always_comb begin
    sum     = SUM_W'(base) + SUM_W'(cnt);
    wrapped = (sum >= SUM_W'(ENTRIES)) ? (sum & SUM_W'(ENTRIES - 1)) : sum;
    slot    = wrapped[IDX_W-1:0];
  end
endmodule

// File: rtl/flow_probe_skid.sv
module flow_probe_skid #(
  parameter int MAX_SKID = 16,
  parameter int CFG_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             busy,
  input  logic [CFG_W-1:0] val,
  output logic [CFG_W-1:0] skid_q
);
  logic [CFG_W-1:0] clamped;

  always_comb begin
    if (val == '0)                       clamped = CFG_W'(1);
    else if (val > CFG_W'(MAX_SKID))     clamped = CFG_W'(MAX_SKID);
    else                                 clamped = val;
  end

  always_ff @(posedge clk) begin
    if (rst)             skid_q <= CFG_W'(MAX_SKID);
    else if (we && !busy) skid_q <= clamped;
  end

  assert_skid_range_R9: assert property (@(posedge clk) disable iff (rst)
    (skid_q >= CFG_W'(1)) && (skid_q <= CFG_W'(MAX_SKID)));

  assert_skid_hold_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(skid_q));
endmodule

// File: rtl/flow_probe_ctrl.sv
module flow_probe_ctrl
  import flow_probe_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int HASH_W   = 6,
  parameter int MAX_SKID = 16,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int CFG_W   = $clog2(MAX_SKID + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_skid,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [HASH_W-1:0] req_hash,
  input  logic [KEY_W-1:0]  req_key,
  output logic              busy,
  output logic              ram_rd_en,
  output logic [IDX_W-1:0]  ram_rd_addr,
  input  logic              ram_rd_valid,
  input  logic [KEY_W-1:0]  ram_rd_key,
  output logic              done,
  output logic [1:0]        done_status,
  output logic [IDX_W-1:0]  done_index
);
  probe_state_e      state;
  logic              op_q;
  logic [HASH_W-1:0] hash_q;
  flow_key_t         key_q;
  logic [CFG_W-1:0]  probe_q;
  logic [CFG_W-1:0]  skid_q;

  logic [HASH_W-1:0] slot_base;
  logic [CFG_W-1:0]  slot_cnt;
  logic [IDX_W-1:0]  next_slot;
  logic              key_match;
  logic              hit;
  logic              last_probe;
  probe_status_e     hit_status;

  assign busy = (state != PS_IDLE);

  flow_probe_skid #(.MAX_SKID(MAX_SKID), .CFG_W(CFG_W)) u_skid (
    .clk(clk), .rst(rst), .we(cfg_we), .busy(busy),
    .val(cfg_skid), .skid_q(skid_q)
  );

  // first probe uses the request directly, later probes the latched hash
  always_comb begin
    slot_base = busy ? hash_q : req_hash;
    slot_cnt  = busy ? (probe_q + CFG_W'(1)) : '0;
  end

  flow_probe_slot #(.ENTRIES(ENTRIES), .HASH_W(HASH_W), .CNT_W(CFG_W)) u_slot (
    .base(slot_base), .cnt(slot_cnt), .slot(next_slot)
  );

  flow_key_cmp u_cmp (.a(key_q), .b(flow_key_t'(ram_rd_key)), .match(key_match));

  // R2/R3: insert ends on a hole or a duplicate; R4/R5: find ends only on an occupied match
  always_comb begin
    if (op_q == OP_INSERT) begin
      hit        = !ram_rd_valid || key_match;
      hit_status = ram_rd_valid ? ST_EXISTS : ST_OK;
    end else begin
      hit        = ram_rd_valid && key_match;
      hit_status = ST_OK;
    end
    last_probe = (probe_q == (skid_q - CFG_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PS_IDLE;
      op_q        <= OP_INSERT;
      hash_q      <= '0;
      key_q       <= '0;
      probe_q     <= '0;
      ram_rd_en   <= 1'b0;
      ram_rd_addr <= '0;
      done        <= 1'b0;
      done_status <= ST_OK;
      done_index  <= '0;
    end else begin
      ram_rd_en <= 1'b0;
      done      <= 1'b0;
      unique case (state)
        PS_IDLE: if (req_valid) begin
          op_q        <= req_op;
          hash_q      <= req_hash;
          key_q       <= flow_key_t'(req_key);
          probe_q     <= '0;
          ram_rd_en   <= 1'b1;
          ram_rd_addr <= next_slot;
          state       <= PS_WAIT;
        end
        PS_WAIT: state <= PS_CMP;
        PS_CMP: begin
          if (hit || last_probe) begin
            done        <= 1'b1;
            done_status <= hit ? hit_status : ST_RANGE;   // R6
            done_index  <= ram_rd_addr;
            state       <= PS_IDLE;
          end else begin
            probe_q     <= probe_q + CFG_W'(1);
            ram_rd_en   <= 1'b1;
            ram_rd_addr <= next_slot;
            state       <= PS_WAIT;
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  assert_read_in_op_R1: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |-> busy);

  assert_probe_bound_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (probe_q < skid_q));

  assert_status_legal_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_status != 2'd3));
endmodule

// File: tb/flow_probe_ctrl_bench.sv
`timescale 1ns/1ps
module flow_probe_ctrl_bench;
  import flow_probe_pkg::*;

  localparam int ENTRIES  = 16;
  localparam int HASH_W   = 6;
  localparam int MAX_SKID = 16;
  localparam int IDX_W    = 4;
  localparam int CFG_W    = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [CFG_W-1:0]  cfg_skid = '0;
  logic              req_valid = 1'b0;
  logic              req_op = 1'b0;
  logic [HASH_W-1:0] req_hash = '0;
  logic [KEY_W-1:0]  req_key = '0;
  logic              busy, ram_rd_en, done;
  logic [IDX_W-1:0]  ram_rd_addr, done_index;
  logic              ram_rd_valid = 1'b0;
  logic [KEY_W-1:0]  ram_rd_key = '0;
  logic [1:0]        done_status;

  int n_checks = 0;
  int n_fail   = 0;
  int cur_skid = MAX_SKID;
  bit finished = 0;

  logic             mem_v [ENTRIES];
  logic [KEY_W-1:0] mem_k [ENTRIES];

  always #10 clk = ~clk;

  flow_probe_ctrl #(.ENTRIES(ENTRIES), .HASH_W(HASH_W), .MAX_SKID(MAX_SKID)) u_flow_probe_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_skid(cfg_skid),
    .req_valid(req_valid), .req_op(req_op), .req_hash(req_hash), .req_key(req_key),
    .busy(busy), .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr),
    .ram_rd_valid(ram_rd_valid), .ram_rd_key(ram_rd_key),
    .done(done), .done_status(done_status), .done_index(done_index)
  );

  always @(posedge clk) begin
    if (ram_rd_en) begin
      ram_rd_valid <= mem_v[ram_rd_addr];
      ram_rd_key   <= mem_k[ram_rd_addr];
    end
  end

  // tweak 0 = exact key; 1..5 flips one bit in one field (R7)
  function automatic logic [KEY_W-1:0] key_of(input int id, input int tweak);
    flow_key_t k;
    k.src_addr = {96'h0, 32'hC0A8_0000 | 32'(id)};
    k.dst_addr = {32'h2001_0DB8, 64'h0, 32'h0000_0100 + 32'(id)};
    k.src_port = 16'd1000 + 16'(id);
    k.dst_port = 16'd80;
    k.proto    = 8'd6;
    case (tweak)
      1: k.src_addr[127] = ~k.src_addr[127];
      2: k.dst_addr[0]   = ~k.dst_addr[0];
      3: k.src_port[15]  = ~k.src_port[15];
      4: k.dst_port[3]   = ~k.dst_port[3];
      5: k.proto[7]      = ~k.proto[7];
      default: ;
    endcase
    return KEY_W'(k);
  endfunction

  function automatic int eff_skid(input int v);
    if (v == 0) return 1;
    if (v > MAX_SKID) return MAX_SKID;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic set_skid(input int v);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_skid = CFG_W'(v);
    @(negedge clk);
    cfg_we   = 1'b0;
    cur_skid = eff_skid(v);
  endtask

  // reference walk; cfg_mid >= 0 injects a skid write during the search
  task automatic run_op(input logic op, input int h, input logic [KEY_W-1:0] key,
                        input int cfg_mid);
    int  e_stat, e_idx, e_lat, n, slot, sum;
    bit  busy_ok, ended;
    string tag;
    ended = 0;
    e_stat = 2; e_idx = 0; e_lat = 0;
    for (int i = 0; i < cur_skid && !ended; i++) begin
      sum  = h + i;
      slot = (sum >= ENTRIES) ? (sum & (ENTRIES - 1)) : sum;   // R1
      e_idx = slot;
      e_lat = 2 * (i + 1);
      if (op == OP_INSERT) begin
        if (!mem_v[slot]) begin e_stat = 0; ended = 1; end          // R2
        else if (mem_k[slot] == key) begin e_stat = 1; ended = 1; end // R3
      end else begin
        if (mem_v[slot] && mem_k[slot] == key) begin e_stat = 0; ended = 1; end // R4 R5
      end
    end
    if (e_stat == 2) tag = "R6";
    else if (op == OP_INSERT) tag = (e_stat == 1) ? "R3" : "R2";
    else tag = "R5";

    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_hash = HASH_W'(h); req_key = key;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; busy_ok = 1;
    while (!done && n < 100) begin
      if (!busy) busy_ok = 0;
      if (cfg_mid >= 0 && n == 3) begin cfg_we = 1'b1; cfg_skid = CFG_W'(cfg_mid); end
      else cfg_we = 1'b0;
      @(negedge clk);
      n++;
    end
    cfg_we = 1'b0;
    check(done && int'(done_status) == e_stat && int'(done_index) == e_idx &&
          n == e_lat && busy_ok && !busy,
          {tag, "/R1/R8"},
          $sformatf("op=%0d h=%0d skid=%0d got st=%0d idx=%0d lat=%0d busyok=%0d exp st=%0d idx=%0d lat=%0d",
                    op, h, cur_skid, done_status, done_index, n, busy_ok, e_stat, e_idx, e_lat));
    @(negedge clk);
    check(!done, "R8", $sformatf("done held high, got %0d exp 0", done));
  endtask

  initial begin
    int skids[6] = '{0, 1, 2, 5, 16, 25};
    for (int s = 0; s < ENTRIES; s++) begin
      mem_v[s] = !(s == 3 || s == 7 || s == 8 || s == 12);
      mem_k[s] = key_of(s % 6, 0);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !ram_rd_en, "R8",
          $sformatf("reset state busy=%0d done=%0d rd=%0d exp 0 0 0", busy, done, ram_rd_en));

    // R9: reset limit is MAX_SKID; absent key walks all 16 probes
    run_op(OP_FIND, 0, key_of(9, 0), -1);

    // R9: write during busy ignored -> still 16 probes now and after
    run_op(OP_FIND, 5, key_of(9, 0), 2);
    run_op(OP_FIND, 40, key_of(9, 0), -1);

    // sweep: skid limits (incl. 0 and >MAX, R9), ops, hashes, keys (R7 tweaks)
    foreach (skids[si]) begin
      set_skid(skids[si]);
      for (int op = 0; op < 2; op++) begin
        for (int h = 0; h < 64; h += 2) begin
          run_op(logic'(op), h, key_of(0, 0), -1);
          run_op(logic'(op), h, key_of(4, 0), -1);
          run_op(logic'(op), h, key_of(9, 0), -1);
          run_op(logic'(op), h, key_of(1, (h % 5) + 1), -1);   // R7
        end
      end
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule